// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of an external NOR flash. It decides when an embedded program or erase operation inside the flash has finished. A one-cycle `start` pulse latches the status address and the poll budget. The block then issues status reads over a simple request/acknowledge bus, two at a time. Between the two reads of a pair it compares one toggle bit. It also looks at the timeout-fail bit that the flash reports in the second read.

If the toggle bit held still, the operation is over and the block reports success. If the toggle bit moved and the fail bit was clear, the block reads another pair. If the toggle bit moved and the fail bit was set, the block does not trust the first sample: the toggling may have stopped just as the fail bit rose. So it reads one more pair. A quiet pair in that re-test still means success. A moving pair means failure, and the block writes the reset command (data F0h) before it reports. A programmable pair budget ends a poll that never settles with a timeout status. An `abort` input drops polling at once. The next `start` begins again with a fresh first read.

The controller is one state machine with eight states:
- `ST_IDLE`
- `ST_RD_FIRST` and `ST_RD_SECOND`: the normal read pair.
- `ST_CHECK`: decides after a normal pair.
- `ST_RE_FIRST` and `ST_RE_SECOND`: the re-test pair.
- `ST_RE_CHECK`: decides after the re-test.
- `ST_WR_RESET`: writes the reset command.

Transitions:
- Launch (`ST_IDLE`→`ST_RD_FIRST` on `start`).
- Each read state advances on `ack`.
- From `ST_CHECK`:
  - to `ST_IDLE` with success when the toggle bit is quiet;
  - to `ST_RE_FIRST` when it toggled with the fail bit set;
  - to `ST_IDLE` with timeout when the budget is spent;
  - otherwise back to `ST_RD_FIRST`.
- From `ST_RE_CHECK`: to `ST_IDLE` with success when quiet, otherwise to `ST_WR_RESET`.
- From `ST_WR_RESET`: to `ST_IDLE` with failure on `ack`.
- Abort: any busy state goes to `ST_IDLE`.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is asserted, and on its release, `busy`, `done`, `fail`, `timeout`, `rd_req` and `wr_req` are all 0.
- R2: Every bus request targets the address captured at `start`. A request stays asserted with a stable address until `ack` or `abort`. `rd_req` and `wr_req` are never high together.
- R3: When bit 6 (the toggle bit) is equal in the first two status reads, polling ends with `done`=1 and `fail`=0. Exactly two reads are made and no write.
- R4: When bit 6 differs within a pair and bit 5 (fail bit) of the pair's second read is 0, another read pair follows.
- R5: When bit 6 differs within a pair and bit 5 of its second read is 1, exactly two re-test reads follow. If bit 6 is equal across them, polling ends with `done`=1 and `fail`=0, and no write is made.
- R6: If bit 6 still differs across the re-test pair, one write of data F0h to the polled address is made. Polling then ends with `done`=1, `fail`=1 and `timeout`=0.
- R7: With `max_polls`=N≠0, the Nth normal pair that toggles with bit 5 clear ends polling with `done`, `fail` and `timeout` all 1, and no write is made. With N=0 the pair count is unlimited.
- R8: On `abort` while busy, the next cycle shows `busy`=0, no request and `done`=0. No further read is made. The next `start` begins with a new first read and uses no value sampled before the abort.
- R9: `busy` is 1 from the cycle after an accepted `start` until the result appears. `done`, `fail` and `timeout` then hold with `busy`=0 until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches polling when idle |
| abort | input | 1 | Leave polling immediately |
| poll_addr | input | ADDR_W | Address for status reads and the reset write |
| max_polls | input | CNT_W | Normal-pair budget, 0 = unlimited, sampled at start |
| busy | output | 1 | Polling in progress |
| done | output | 1 | A result is available |
| fail | output | 1 | Result is failure or timeout |
| timeout | output | 1 | Result is pair budget exhausted |
| rd_req | output | 1 | Read request, held until ack |
| wr_req | output | 1 | Write request, held until ack |
| addr | output | ADDR_W | Bus address |
| wdata | output | DATA_W | Write data (F0h during the reset write) |
| rdata | input | DATA_W | Read data, valid with ack |
| ack | input | 1 | Transfer complete, one cycle |

## Verification
The hardest path to reach is the re-test that still toggles and so leads to the reset write. It needs a toggling pair whose second read has the fail bit set, followed by two more reads that toggle again. A naive random status source seldom lines these up before the block finishes. The bench therefore plays back stored status sequences and draws them with a random busy length and a random read index at which the fail bit rises. It also includes directed sequences that force each branch. A further delicate case is an abort placed between the two reads of a pair, followed by a restart that must not reuse the stale first sample. A fixed acknowledge delay makes that window wide enough to hit deliberately.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_SECOND,
        ST_CHECK,
        ST_RE_FIRST,
        ST_RE_SECOND,
        ST_RE_CHECK,
        ST_WR_RESET
    } poll_state_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_OK,
        RES_FAIL,
        RES_TIMEOUT
    } poll_result_e;

endpackage

// File: rtl/fdp_bit_sampler.sv
// Holds the toggle bit of the first read of a pair, then registers whether
// the second read differed and what its fail bit was.
module fdp_bit_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic take_first,
    input  logic take_second,
    input  logic tog_in,
    input  logic fail_in,
    output logic toggled,
    output logic fail_seen
);
    logic first_q;
    logic tog_q;
    logic fail_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            tog_q   <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            if (take_first) begin
                first_q <= tog_in;
            end
            if (take_second) begin
                tog_q  <= first_q ^ tog_in;
                fail_q <= fail_in;
            end
        end
    end

    assign toggled   = tog_q;
    assign fail_seen = fail_q;

endmodule

// File: rtl/fdp_pair_counter.sv
// Counts normal read pairs that ended toggling with the fail bit clear.
// at_limit is high while the next such pair would reach the budget.
module fdp_pair_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             bump,
    output logic             at_limit
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W:0]   count_plus;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            limit_q <= '0;
        end else if (clear) begin
            count_q <= '0;
            limit_q <= limit_in;
        end else if (bump && (count_q != {CNT_W{1'b1}})) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_plus = {1'b0, count_q} + {{CNT_W{1'b0}}, 1'b1};
    assign at_limit   = (limit_q != '0) && (count_plus >= {1'b0, limit_q});

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import fdp_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter int                DATA_W     = 8,
    parameter int                CNT_W      = 16,
    parameter int                TOGGLE_BIT = 6,
    parameter int                FAIL_BIT   = 5,
    parameter logic [DATA_W-1:0] RESET_CMD  = DATA_W'(8'hF0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic [CNT_W-1:0]  max_polls,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              timeout,
    output logic              rd_req,
    output logic              wr_req,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata,
    input  logic              ack
);
    poll_state_e       state_q, state_d;
    poll_result_e      result_q, result_d;
    logic [ADDR_W-1:0] addr_q;

    logic launch;
    logic take_first;
    logic take_second;
    logic toggled;
    logic fail_seen;
    logic at_limit;
    logic bump;
    logic unused_rdata_bits;

    assign unused_rdata_bits = ^rdata;

    assign launch      = (state_q == ST_IDLE) && start;
    assign take_first  = ack && ((state_q == ST_RD_FIRST)  || (state_q == ST_RE_FIRST));
    assign take_second = ack && ((state_q == ST_RD_SECOND) || (state_q == ST_RE_SECOND));
    assign bump        = (state_q == ST_CHECK) && toggled && !fail_seen;

    fdp_bit_sampler u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_first  (take_first),
        .take_second (take_second),
        .tog_in      (rdata[TOGGLE_BIT]),
        .fail_in     (rdata[FAIL_BIT]),
        .toggled     (toggled),
        .fail_seen   (fail_seen)
    );

    fdp_pair_counter #(
        .CNT_W (CNT_W)
    ) u_pairs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (launch),
        .limit_in (max_polls),
        .bump     (bump),
        .at_limit (at_limit)
    );

    // Next state and result
    always_comb begin
        state_d  = state_q;
        result_d = result_q;
        if (abort && (state_q != ST_IDLE)) begin
            state_d  = ST_IDLE;
            result_d = RES_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_d  = ST_RD_FIRST;
                        result_d = RES_NONE;
                    end
                end
                ST_RD_FIRST: begin
                    if (ack) state_d = ST_RD_SECOND;
                end
                ST_RD_SECOND: begin
                    if (ack) state_d = ST_CHECK;
                end
                ST_CHECK: begin
                    if (!toggled) begin
                        state_d  = ST_IDLE;
                        result_d = RES_OK;
                    end else if (fail_seen) begin
                        state_d = ST_RE_FIRST;
                    end else if (at_limit) begin
                        state_d  = ST_IDLE;
                        result_d = RES_TIMEOUT;
                    end else begin
                        state_d = ST_RD_FIRST;
                    end
                end
                ST_RE_FIRST: begin
                    if (ack) state_d = ST_RE_SECOND;
                end
                ST_RE_SECOND: begin
                    if (ack) state_d = ST_RE_CHECK;
                end
                ST_RE_CHECK: begin
                    if (!toggled) begin
                        state_d  = ST_IDLE;
                        result_d = RES_OK;
                    end else begin
                        state_d = ST_WR_RESET;
                    end
                end
                ST_WR_RESET: begin
                    if (ack) begin
                        state_d  = ST_IDLE;
                        result_d = RES_FAIL;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= RES_NONE;
            addr_q   <= '0;
        end else begin
            state_q  <= state_d;
            result_q <= result_d;
            if (launch) begin
                addr_q <= poll_addr;
            end
        end
    end

    // Outputs
    always_comb begin
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        wdata   = '0;
        addr    = addr_q;
        busy    = (state_q != ST_IDLE);
        done    = (result_q != RES_NONE);
        fail    = (result_q == RES_FAIL) || (result_q == RES_TIMEOUT);
        timeout = (result_q == RES_TIMEOUT);
        unique case (state_q)
            ST_RD_FIRST, ST_RD_SECOND, ST_RE_FIRST, ST_RE_SECOND: rd_req = 1'b1;
            ST_WR_RESET: begin
                wr_req = 1'b1;
                wdata  = RESET_CMD;
            end
            ST_IDLE, ST_CHECK, ST_RE_CHECK: ;
        endcase
    end

endmodule

// File: rtl/fdp_poller_checks.sv
module fdp_poller_checks #(
    parameter int                ADDR_W    = 24,
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] RESET_CMD = DATA_W'(8'hF0)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              abort,
    input logic              ack,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              timeout,
    input logic              rd_req,
    input logic              wr_req,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata
);

    p_excl_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !ack && !abort) |=> (rd_req && $stable(addr)));

    p_reset_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wdata == RESET_CMD));

    p_timeout_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (fail && done));

    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> (!busy && !rd_req && !wr_req && !done));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

bind flash_done_poller fdp_poller_checks #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RESET_CMD (RESET_CMD)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .abort   (abort),
    .ack     (ack),
    .busy    (busy),
    .done    (done),
    .fail    (fail),
    .timeout (timeout),
    .rd_req  (rd_req),
    .wr_req  (wr_req),
    .addr    (addr),
    .wdata   (wdata)
);

// File: tb/flash_done_poller_tb.sv
module flash_done_poller_tb;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              abort = 1'b0;
    logic [ADDR_W-1:0] poll_addr = '0;
    logic [CNT_W-1:0]  max_polls = '0;
    logic              busy, done, fail, timeout, rd_req, wr_req;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata = '0;
    logic              ack = 1'b0;

    always #2 clk = ~clk;

    flash_done_poller #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .poll_addr(poll_addr), .max_polls(max_polls),
        .busy(busy), .done(done), .fail(fail), .timeout(timeout),
        .rd_req(rd_req), .wr_req(wr_req), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ack(ack)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] sts [64];
    int rd_idx = 0;
    int wr_cnt = 0;
    int bad_addr = 0;
    int resp_max = 0;
    int resp_fix = -1;
    int wait_cnt = 0;
    logic [ADDR_W-1:0] cur_addr = '0;
    logic [ADDR_W-1:0] last_wr_addr = '0;
    logic [DATA_W-1:0] last_wr_data = '0;

    function automatic logic [7:0] rd_at(input int i);
        return sts[(i > 63) ? 63 : i];
    endfunction

    // Bus responder: plays back sts[] for reads, records writes.
    always @(negedge clk) begin
        if (ack) begin
            ack = 1'b0;
        end else if (rd_req || wr_req) begin
            if (wait_cnt > 0) begin
                wait_cnt--;
            end else begin
                ack = 1'b1;
                if (addr != cur_addr) bad_addr++;
                if (rd_req) begin
                    rdata = rd_at(rd_idx);
                    rd_idx++;
                end else begin
                    wr_cnt++;
                    last_wr_addr = addr;
                    last_wr_data = wdata;
                    rdata = '0;
                end
                wait_cnt = (resp_fix >= 0) ? resp_fix : int'($urandom_range(resp_max, 0));
            end
        end
    end

    task automatic chk(input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Expected outcome from the requirements: res 0 ok, 1 fail, 2 timeout
    function automatic void predict(input int maxp, output int res, output int nreads, output int nwr);
        int i = 0;
        int pairs = 0;
        res = -1;
        nwr = 0;
        while (res < 0 && i < 400) begin
            logic [7:0] a = rd_at(i);
            logic [7:0] b = rd_at(i + 1);
            i += 2;
            if (a[6] == b[6]) begin
                res = 0;
            end else if (b[5]) begin
                logic [7:0] c = rd_at(i);
                logic [7:0] d = rd_at(i + 1);
                i += 2;
                if (c[6] == d[6]) res = 0;
                else begin
                    res = 1;
                    nwr = 1;
                end
            end else begin
                pairs++;
                if (maxp != 0 && pairs >= maxp) res = 2;
            end
        end
        nreads = i;
    endfunction

    task automatic run_poll(input int maxp, input string tag);
        int res, nr, nw, cyc;
        predict(maxp, res, nr, nw);
        @(negedge clk);
        rd_idx = 0; wr_cnt = 0; bad_addr = 0;
        max_polls = CNT_W'(maxp);
        cur_addr = ADDR_W'($urandom);
        poll_addr = cur_addr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        poll_addr = ~cur_addr;
        chk($sformatf("%s R9 busy after start", tag), busy, 1);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk($sformatf("%s R9 done reached", tag), done, 1);
        chk($sformatf("%s fail flag", tag), fail, (res != 0) ? 1 : 0);
        chk($sformatf("%s R7 timeout flag", tag), timeout, (res == 2) ? 1 : 0);
        chk($sformatf("%s read count", tag), rd_idx, nr);
        chk($sformatf("%s R6 write count", tag), wr_cnt, nw);
        if (nw != 0) begin
            chk($sformatf("%s R6 write data", tag), last_wr_data, 8'hF0);
            chk($sformatf("%s R6 write addr", tag), last_wr_addr, cur_addr);
        end
        chk($sformatf("%s R2 address", tag), bad_addr, 0);
        repeat (3) @(negedge clk);
        chk($sformatf("%s R9 result held", tag), {busy, done, fail, timeout},
            {1'b0, 1'b1, (res != 0), (res == 2)});
    endtask

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < 64; i++) sts[i] = v;
    endtask

    task automatic fill_alt();
        for (int i = 0; i < 64; i++) sts[i] = i[0] ? 8'h40 : 8'h00;
    endtask

    task automatic gen_random();
        int busy_len = $urandom_range(40, 0);
        int fail_at  = $urandom_range(60, 0);
        logic t = 1'($urandom_range(1, 0));
        for (int i = 0; i < 64; i++) begin
            logic [7:0] v = 8'($urandom);
            if (i < busy_len && $urandom_range(3, 0) != 0) t = ~t;
            v[6] = t;
            v[5] = (i >= fail_at);
            sts[i] = v;
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        process::self().srandom(32'h5eed_0042);
        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1 outputs in reset", {busy, done, fail, timeout, rd_req, wr_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", {busy, done, fail, timeout, rd_req, wr_req}, 0);

        resp_max = 2;
        // R3: quiet toggle bit on first pair
        fill(8'h80);
        run_poll(0, "R3 immediate");
        // R4: two toggling pairs without fail, then quiet, unlimited budget
        fill(8'h40);
        sts[0] = 8'h00; sts[1] = 8'h40; sts[2] = 8'h00; sts[3] = 8'h40;
        run_poll(0, "R4 continue");
        // R5: toggle with fail bit, re-test quiet
        fill(8'h20);
        sts[0] = 8'h00; sts[1] = 8'h60;
        run_poll(0, "R5 recheck ok");
        // R6: toggle with fail bit, re-test still toggling
        fill(8'h20);
        sts[0] = 8'h00; sts[1] = 8'h60; sts[2] = 8'h20; sts[3] = 8'h60;
        run_poll(0, "R6 recheck fail");
        // R7: budget of one pair and of three pairs
        fill_alt();
        run_poll(1, "R7 budget one");
        run_poll(3, "R7 budget three");

        // R8: abort between the two reads of a pair, then restart fresh
        resp_fix = 4;
        fill(8'h40);
        @(negedge clk);
        rd_idx = 0; wr_cnt = 0; bad_addr = 0;
        cur_addr = 24'h00_1234; poll_addr = cur_addr; max_polls = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (rd_idx == 1);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R8 quiet after abort", {busy, rd_req, wr_req, done}, 0);
        repeat (8) @(negedge clk);
        chk("R8 no read after abort", rd_idx, 1);
        chk("R8 no result after abort", done, 0);
        fill(8'h00);
        run_poll(0, "R8 restart from first read");
        resp_fix = -1;

        // Random sequences against the reference prediction
        resp_max = 3;
        for (int k = 0; k < 60; k++) begin
            int mp = ($urandom_range(3, 0) == 0) ? 0 : int'($urandom_range(12, 1));
            int res, nr, nw;
            gen_random();
            predict(mp, res, nr, nw);
            if (res == 1) run_poll(mp, $sformatf("R6 random %0d", k));
            else if (res == 2) run_poll(mp, $sformatf("R7 random %0d", k));
            else if (nr > 2) run_poll(mp, $sformatf("R5 random %0d", k));
            else run_poll(mp, $sformatf("R3 random %0d", k));
        end

        summary();
    end

endmodule